// File: doc/BRIEF.md
# Brown-out release sequencer

This block takes a device out of internal reset after a power-on or brown-out event. Either event forces the block into a reset-assert state that holds the core in reset and keeps the system clock gated. In that state the block captures the clock configuration: a 3-bit source select, a 2-bit primary-oscillator mode, a PLL-use bit and a 3-bit power-up delay select. From these it works out which timers the next sequence needs.

After the event clears, the block waits out a fixed regulator start-up interval. It then enters a qualification phase in which three things run side by side. The oscillator start-up count runs only when a crystal is in use. The PLL lock wait applies only when the PLL is used. The power-up delay is either the selected power-up timer or, when that timer is off and a crystal is in use, a fixed fail-safe delay. The clock is enabled once the oscillator is qualified. Reset is released once every condition holds at the same time.

Sticky status flags record whether the last event was a brown-out or a power-on, and software clears them with write-one-to-clear strobes. Clock multiplexing and the analog monitor sit outside this block: the block outputs the captured clock-select code and receives the comparator result as a synchronous flag. Timer lengths are parameters counted in reference-clock cycles: `REG_CYC` for the start-up interval, `MS_CYC` per millisecond, `FSCM_CYC` for the fail-safe delay and `OST_CNT` oscillator ticks.

Top module: `brownout_release_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs read `core_rst_o`=1, `clk_en_o`=0, `state_o`=0, `clk_src_o`=0, `bor_stat_o`=0 and `por_stat_o`=0.
- R2: Whenever `bor_i` or `por_i` is sampled high, in any state, the next cycle shows `state_o`=0 (reset-assert), `core_rst_o`=1 and `clk_en_o`=0. The block stays there while either flag remains high, and the sequence then starts again from the beginning.
- R3: Reset-assert lasts one cycle once both flags are low. In that cycle the block captures `clk_src_o` = {`osc_sel_i`, `pri_mode_i`}, along with the PLL-use and delay-select inputs. Configuration changes at any other time have no effect until the next reset-assert.
- R4: The regulator start-up state (`state_o`=1) lasts exactly `REG_CYC`+1 cycles, and the clock stays gated throughout.
- R5: A crystal is in use when `osc_sel_i[2:1]`=2'b01 and `pri_mode_i[1]`=0. Only then must `OST_CNT` cycles of `osc_tick_i` be sampled in earlier qualification cycles (`state_o`=2) before the oscillator counts as qualified; otherwise it is qualified at once.
- R6: When the PLL-use bit was captured as 1, the clock qualifies only in a cycle where `pll_lock_i` is sampled 1.
- R7: The power-up delay is `MS_CYC`<<sel cycles for a nonzero delay select sel. For sel=0 it is `FSCM_CYC` cycles when a crystal is in use and 0 otherwise. The delay is met in qualification cycle N (counting from 0) once N ≥ the delay.
- R8: `core_rst_o` falls, and `state_o` becomes 3 (run), on the cycle after a qualification cycle in which the oscillator, the PLL condition and the power-up delay are all met. Run holds until the next event.
- R9: `clk_en_o` is 1 on the cycle after each qualification cycle in which the clock is qualified, and it stays 1 in run. It is 0 in reset-assert and in regulator start-up.
- R10: A sampled `bor_i` without `por_i` sets `bor_stat_o` on the next cycle. The flag then stays set until `stat_clr_i[0]` is sampled high in a cycle with no event.
- R11: A sampled `por_i` sets `por_stat_o` and clears `bor_stat_o` on the next cycle. `stat_clr_i[1]` clears `por_stat_o` when `por_i` is low.
- R12: `state_o` encodes reset-assert=0, regulator start-up=1, qualification=2 and run=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bor_i | input | 1 | Synchronous brown-out comparator flag |
| por_i | input | 1 | Power-on event flag |
| osc_sel_i | input | 3 | Clock source select configuration |
| pri_mode_i | input | 2 | Primary oscillator mode configuration |
| pll_use_i | input | 1 | PLL is used by the selected source |
| pwrt_sel_i | input | 3 | Power-up delay select, 0 = timer off |
| pll_lock_i | input | 1 | PLL lock indication |
| osc_tick_i | input | 1 | One-cycle strobe per oscillator cycle |
| stat_clr_i | input | 2 | Write-one-to-clear: bit 0 brown-out flag, bit 1 power-on flag |
| core_rst_o | output | 1 | Internal device reset |
| clk_en_o | output | 1 | System clock enable (0 = gated) |
| clk_src_o | output | 5 | Captured clock-select code {osc_sel, pri_mode} |
| bor_stat_o | output | 1 | Sticky brown-out status |
| por_stat_o | output | 1 | Sticky power-on status |
| state_o | output | 2 | Sequencer state for test |

## Verification
Every output is registered, so the response to the inputs sampled at one rising edge appears right after that edge. The bench drives inputs after its compare, well clear of the edge, and updates a cycle-level reference model at each edge before comparing all six outputs. Release latency is also measured directly and compared with 1 + (`REG_CYC`+1) + (max of oscillator and power-up limits + 1) cycles, counted from the first cycle with no event. A PLL that locks late releases reset one cycle after lock is sampled.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [1:0] {
    ST_RSTA  = 2'd0,
    ST_REGUP = 2'd1,
    ST_QUAL  = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_t;

  // crystal: source uses the primary oscillator and the mode is a crystal mode
  function automatic logic is_crystal(input logic [2:0] sel, input logic [1:0] mode);
    return (sel[2:1] == 2'b01) && !mode[1];
  endfunction

endpackage

// File: rtl/brs_timer.sv
module brs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q < limit_i)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = arm_i && (cnt_q >= limit_i);

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst) (arm_i && $past(arm_i) && $past(limit_i) == limit_i) |-> cnt_q <= limit_i); // R7

endmodule

// File: rtl/brs_cfg.sv
module brs_cfg
  import brs_pkg::*;
#(
  parameter int MS_CYC   = 50000,
  parameter int FSCM_CYC = 5000,
  parameter int OST_CNT  = 1024,
  parameter int PW       = 24,
  parameter int OW       = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture_i,
  input  logic [2:0]    osc_sel_i,
  input  logic [1:0]    pri_mode_i,
  input  logic          pll_use_i,
  input  logic [2:0]    pwrt_sel_i,
  output logic [4:0]    clk_src_o,
  output logic          pll_use_o,
  output logic [OW-1:0] ost_lim_o,
  output logic [PW-1:0] pwr_lim_o
);

  logic          xtal;
  logic [PW-1:0] pwr_lim_n;

  assign xtal = is_crystal(osc_sel_i, pri_mode_i);

  always_comb begin
    if (pwrt_sel_i != 3'd0) begin
      pwr_lim_n = PW'(MS_CYC) << pwrt_sel_i;
    end else if (xtal) begin
      pwr_lim_n = PW'(FSCM_CYC);
    end else begin
      pwr_lim_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_src_o <= '0;
      pll_use_o <= 1'b0;
      ost_lim_o <= '0;
      pwr_lim_o <= '0;
    end else if (capture_i) begin
      clk_src_o <= {osc_sel_i, pri_mode_i};
      pll_use_o <= pll_use_i;
      ost_lim_o <= xtal ? OW'(OST_CNT) : '0;
      pwr_lim_o <= pwr_lim_n;
    end
  end

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (rst) !$past(capture_i) |-> $stable(clk_src_o)); // R3

endmodule

// File: rtl/brs_status.sv
module brs_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       bor_i,
  input  logic       por_i,
  input  logic [1:0] clr_i,
  output logic       bor_stat_o,
  output logic       por_stat_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bor_stat_o <= 1'b0;
      por_stat_o <= 1'b0;
    end else begin
      if (por_i) begin
        bor_stat_o <= 1'b0;
      end else if (bor_i) begin
        bor_stat_o <= 1'b1;
      end else if (clr_i[0]) begin
        bor_stat_o <= 1'b0;
      end
      if (por_i) begin
        por_stat_o <= 1'b1;
      end else if (clr_i[1]) begin
        por_stat_o <= 1'b0;
      end
    end
  end

  AST_BOR_STICKY: assert property (@(posedge clk) disable iff (rst) (bor_stat_o && !clr_i[0] && !por_i) |=> bor_stat_o); // R10
  AST_POR_CLEARS: assert property (@(posedge clk) disable iff (rst) por_i |=> (por_stat_o && !bor_stat_o)); // R11

endmodule

// File: rtl/brownout_release_seq.sv
module brownout_release_seq
  import brs_pkg::*;
#(
  parameter int REG_CYC  = 1000,
  parameter int MS_CYC   = 50000,
  parameter int FSCM_CYC = 5000,
  parameter int OST_CNT  = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bor_i,
  input  logic       por_i,
  input  logic [2:0] osc_sel_i,
  input  logic [1:0] pri_mode_i,
  input  logic       pll_use_i,
  input  logic [2:0] pwrt_sel_i,
  input  logic       pll_lock_i,
  input  logic       osc_tick_i,
  input  logic [1:0] stat_clr_i,
  output logic       core_rst_o,
  output logic       clk_en_o,
  output logic [4:0] clk_src_o,
  output logic       bor_stat_o,
  output logic       por_stat_o,
  output logic [1:0] state_o
);

  localparam int RW = $clog2(REG_CYC + 2);
  localparam int PW = $clog2(MS_CYC * 128 + FSCM_CYC + 2);
  localparam int OW = $clog2(OST_CNT + 2);

  seq_state_t    state_q, state_n;
  logic          core_rst_q, clk_en_q;
  logic          reg_done, ost_done, pwr_done, clk_qual;
  logic          cfg_pll;
  logic [OW-1:0] ost_lim;
  logic [PW-1:0] pwr_lim;
  logic          event_seen;

  assign event_seen = bor_i || por_i;

  brs_cfg #(
    .MS_CYC  (MS_CYC),
    .FSCM_CYC(FSCM_CYC),
    .OST_CNT (OST_CNT),
    .PW      (PW),
    .OW      (OW)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .capture_i (state_q == ST_RSTA),
    .osc_sel_i (osc_sel_i),
    .pri_mode_i(pri_mode_i),
    .pll_use_i (pll_use_i),
    .pwrt_sel_i(pwrt_sel_i),
    .clk_src_o (clk_src_o),
    .pll_use_o (cfg_pll),
    .ost_lim_o (ost_lim),
    .pwr_lim_o (pwr_lim)
  );

  brs_timer #(.W(RW)) u_reg_tmr (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (state_q == ST_REGUP),
    .tick_i (1'b1),
    .limit_i(RW'(REG_CYC)),
    .done_o (reg_done)
  );

  brs_timer #(.W(OW)) u_ost_tmr (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (state_q == ST_QUAL),
    .tick_i (osc_tick_i),
    .limit_i(ost_lim),
    .done_o (ost_done)
  );

  brs_timer #(.W(PW)) u_pwr_tmr (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (state_q == ST_QUAL),
    .tick_i (1'b1),
    .limit_i(pwr_lim),
    .done_o (pwr_done)
  );

  brs_status u_status (
    .clk       (clk),
    .rst       (rst),
    .bor_i     (bor_i),
    .por_i     (por_i),
    .clr_i     (stat_clr_i),
    .bor_stat_o(bor_stat_o),
    .por_stat_o(por_stat_o)
  );

  assign clk_qual = ost_done && (!cfg_pll || pll_lock_i);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RSTA:  state_n = ST_REGUP;
      ST_REGUP: if (reg_done) state_n = ST_QUAL;
      ST_QUAL:  if (clk_qual && pwr_done) state_n = ST_RUN;
      default:  state_n = ST_RUN;
    endcase
    if (event_seen) state_n = ST_RSTA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RSTA;
      core_rst_q <= 1'b1;
      clk_en_q   <= 1'b0;
    end else begin
      state_q    <= state_n;
      core_rst_q <= (state_n != ST_RUN);
      clk_en_q   <= (state_n == ST_RUN) || ((state_n == ST_QUAL) && clk_qual);
    end
  end

  assign core_rst_o = core_rst_q;
  assign clk_en_o   = clk_en_q;
  assign state_o    = state_q;

  AST_EVT_RESTART: assert property (@(posedge clk) disable iff (rst) event_seen |=> (state_o == 2'd0 && core_rst_o && !clk_en_o)); // R2
  AST_GATE_EARLY: assert property (@(posedge clk) disable iff (rst) (state_q == ST_RSTA || state_q == ST_REGUP) |-> !clk_en_o); // R9
  AST_REL_COND: assert property (@(posedge clk) disable iff (rst) (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> ($past(state_q) == ST_QUAL && $past(ost_done) && $past(pwr_done))); // R8
  AST_PLL_LOCK: assert property (@(posedge clk) disable iff (rst) ($rose(clk_en_o) && cfg_pll && $past(state_q) == ST_QUAL) |-> $past(pll_lock_i)); // R6
  AST_RUN_OPEN: assert property (@(posedge clk) disable iff (rst) (state_q == ST_RUN) |-> (clk_en_o && !core_rst_o)); // R8

endmodule

// File: tb/brownout_release_seq_tb.sv
module brownout_release_seq_tb;

  localparam int REG  = 4;
  localparam int MS   = 3;
  localparam int FSCM = 6;
  localparam int OST  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bor = 1'b0, por = 1'b0, pll_use = 1'b0, lock = 1'b1, tick = 1'b1;
  logic [2:0] osc_sel = 3'd0, psel = 3'd0;
  logic [1:0] pri = 2'd0, clr = 2'd0;
  logic core_rst, clk_en, bor_stat, por_stat;
  logic [4:0] src;
  logic [1:0] st;

  always #10 clk = ~clk;

  brownout_release_seq #(.REG_CYC(REG), .MS_CYC(MS), .FSCM_CYC(FSCM), .OST_CNT(OST)) u_dut (
    .clk(clk), .rst(rst), .bor_i(bor), .por_i(por), .osc_sel_i(osc_sel), .pri_mode_i(pri),
    .pll_use_i(pll_use), .pwrt_sel_i(psel), .pll_lock_i(lock), .osc_tick_i(tick),
    .stat_clr_i(clr), .core_rst_o(core_rst), .clk_en_o(clk_en), .clk_src_o(src),
    .bor_stat_o(bor_stat), .por_stat_o(por_stat), .state_o(st)
  );

  int errors = 0, checks = 0, wd = 0;
  // reference model state
  int ms = 0, m_reg = 0, m_ost = 0, m_pwr = 0, m_src = 0, m_psel = 0;
  bit m_clk = 0, m_xtal = 0, m_pll = 0, m_bor = 0, m_por = 0;

  function automatic bit xtal_of(int s, int p);
    return (s >> 1) == 1 && p < 2;
  endfunction
  function automatic int ost_limit(bit x);
    return x ? OST : 0;
  endfunction
  function automatic int pwr_limit(bit x, int ps);
    if (ps != 0) return MS << ps;
    return x ? FSCM : 0;
  endfunction
  function automatic int rel_cycles(bit x, int ps);
    int a = ost_limit(x), b = pwr_limit(x, ps);
    return 1 + (REG + 1) + ((a > b) ? a : b) + 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit qual, pdone, rdone;
    int ns, ol, pl;
    if (rst) begin
      ms = 0; m_reg = 0; m_ost = 0; m_pwr = 0; m_src = 0; m_psel = 0;
      m_clk = 0; m_xtal = 0; m_pll = 0; m_bor = 0; m_por = 0;
      return;
    end
    ol = ost_limit(m_xtal);
    pl = pwr_limit(m_xtal, m_psel);
    qual  = (ms == 2) && (m_ost >= ol) && (!m_pll || lock);
    pdone = (ms == 2) && (m_pwr >= pl);
    rdone = (ms == 1) && (m_reg >= REG);
    if (bor || por) ns = 0;
    else if (ms == 0) ns = 1;
    else if (ms == 1) ns = rdone ? 2 : 1;
    else if (ms == 2) ns = (qual && pdone) ? 3 : 2;
    else ns = 3;
    m_reg = (ms == 1) ? ((m_reg < REG) ? m_reg + 1 : m_reg) : 0;
    m_ost = (ms == 2) ? ((tick && m_ost < ol) ? m_ost + 1 : m_ost) : 0;
    m_pwr = (ms == 2) ? ((m_pwr < pl) ? m_pwr + 1 : m_pwr) : 0;
    if (ms == 0) begin
      m_src = {osc_sel, pri}; m_pll = pll_use; m_psel = psel; m_xtal = xtal_of(osc_sel, pri);
    end
    m_clk = (ns == 3) || (ns == 2 && qual);
    if (por) m_bor = 0; else if (bor) m_bor = 1; else if (clr[0]) m_bor = 0;
    if (por) m_por = 1; else if (clr[1]) m_por = 0;
    ms = ns;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #2;
    chk("R8 core_rst", core_rst, (ms != 3));
    chk("R9 clk_en", clk_en, m_clk);
    chk("R12 state", st, ms);
    chk("R3 clk_src", src, m_src);
    chk("R10 bor_stat", bor_stat, m_bor);
    chk("R11 por_stat", por_stat, m_por);
  endtask

  // pulse an event, then count cycles until reset is released
  task automatic event_and_measure(input bit use_bor, input int exp, input string tag);
    int n = 0;
    if (use_bor) bor = 1; else por = 1;
    cyc();
    bor = 0; por = 0;
    while (core_rst && n < 2000) begin
      cyc();
      n++;
    end
    chk(tag, n, exp);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int sd;
    sd = $urandom(32'd4321);
    // R1 reset state
    repeat (3) cyc();
    chk("R1 core_rst", core_rst, 1); chk("R1 clk_en", clk_en, 0);
    chk("R1 state", st, 0); chk("R1 stat", {bor_stat, por_stat}, 0);
    rst = 0;
    cyc();
    chk("R1 src after reset", src, 0);

    // crystal, power-up timer off: fail-safe delay (R7), power-on flag (R11)
    osc_sel = 3'd2; pri = 2'd0; pll_use = 0; psel = 0; tick = 1; lock = 1;
    event_and_measure(0, rel_cycles(1, 0), "R7 fail-safe release");
    chk("R11 por set", por_stat, 1);
    chk("R9 clk on in run", clk_en, 1);

    // crystal with a 4 ms delay select, brown-out (R7, R10)
    psel = 3'd2;
    event_and_measure(1, rel_cycles(1, 2), "R7 delay select release");
    chk("R10 bor set", bor_stat, 1);

    // no crystal, timer off: no oscillator count (R5)
    osc_sel = 3'd0; psel = 0;
    event_and_measure(1, rel_cycles(0, 0), "R5 no crystal release");

    // regulator start-up length (R4)
    osc_sel = 3'd2; pri = 2'd1;
    bor = 1; cyc(); bor = 0; cyc();
    chk("R4 enter regup", st, 1);
    for (int i = 0; i < REG; i++) cyc();
    chk("R4 still regup", st, 1);
    chk("R4 clock gated", clk_en, 0);
    cyc();
    chk("R4 leave regup", st, 2);
    while (core_rst) cyc();

    // PLL lock held off (R6)
    osc_sel = 3'd3; pri = 2'd1; pll_use = 1; lock = 0; psel = 0;
    bor = 1; cyc(); bor = 0;
    repeat (40) cyc();
    chk("R6 gated without lock", clk_en, 0);
    chk("R6 held in reset", core_rst, 1);
    lock = 1;
    cyc();
    chk("R6 release after lock", core_rst, 0);
    pll_use = 0;

    // config change mid-sequence is ignored (R3)
    osc_sel = 3'd2; pri = 2'd0;
    bor = 1; cyc(); bor = 0; cyc(); cyc();
    osc_sel = 3'd7; pri = 2'd3; psel = 3'd7;
    while (core_rst) cyc();
    chk("R3 src kept", src, 5'b01000);
    osc_sel = 3'd2; pri = 2'd0; psel = 0;

    // brown-out inside qualification restarts (R2)
    bor = 1; cyc(); bor = 0;
    repeat (REG + 4) cyc();
    chk("R2 in qual", st, 2);
    event_and_measure(1, rel_cycles(1, 0), "R2 restart release");

    // clear strobes (R10, R11)
    clr = 2'b01; cyc(); clr = 2'b00; cyc();
    chk("R10 cleared", bor_stat, 0);
    clr = 2'b10; cyc(); clr = 2'b00; cyc();
    chk("R11 cleared", por_stat, 0);
    bor = 1; por = 1; cyc(); bor = 0; por = 0; cyc();
    chk("R11 por over bor", {bor_stat, por_stat}, 2'b01);

    // constrained random against the model
    for (int k = 0; k < 6000; k++) begin
      tick = ($urandom % 4) != 0;
      if ($urandom % 20 == 0) lock = ~lock;
      bor = ($urandom % 180) == 0;
      por = ($urandom % 900) == 0;
      clr = ($urandom % 40 == 0) ? 2'($urandom) : 2'b00;
      if ($urandom % 25 == 0) begin
        osc_sel = 3'($urandom); pri = 2'($urandom); pll_use = 1'($urandom);
        psel = ($urandom % 3 == 0) ? 3'($urandom) : 3'd0;
      end
      cyc();
    end
    bor = 0; por = 0; clr = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule